// File: doc/BRIEF.md
# Luma Contrast and Chroma Saturation Gain

This block scales a YCbCr pixel stream one pixel at a time. Luma is multiplied by a contrast gain. The two chroma components each get a saturation gain of their own. Each gain is an 8-bit code where gain = code/128. A code of 0x00 gives zero, 0x80 gives exactly one, and 0xFF gives just under two. Chroma is scaled about the neutral level 128, so changing saturation changes colour intensity without turning the hue. Brightness offset and clamping belong to other stages, and these gains do not interact with them.

A pixel is presented with a valid strobe. Its scaled result appears two clock edges later with a matching valid. The three gain codes are loaded through a small write port that has a select and a data byte. A new code applies to pixels accepted after the write edge.

Top module: `ycc_gain_stage`

## Requirements
- R1: After reset all three gain codes are 0x80, `out_vld` is 0 and all three output components are 0.
- R2: A pixel sampled with `in_vld` high at clock edge N produces `out_vld` high after edge N+1. `out_vld` is low for every other cycle, and back-to-back pixels emerge back to back in order.
- R3: Luma output is min(255, floor((Y*Gy + 64)/128)), where Gy is the contrast code. With Gy = 0x80 the output equals the input Y exactly.
- R4: A contrast code of 0x00 drives the luma output to 0. With code 0xFF, large luma values saturate at 255.
- R5: Each chroma output is clamp(floor(((C-128)*G + 64)/128) + 128, 0, 255), using that component's own code G. A code of 0x00 yields 128, and code 0xFF saturates at both 0 and 255.
- R6: The Cb code affects only `out_cb`, and the Cr code affects only `out_cr`. Neither changes `out_y` or the other chroma output.
- R7: A write with `wr_en` high loads `wr_data` into the register chosen by `wr_sel`: 0 selects contrast, 1 selects Cb saturation and 2 selects Cr saturation. `wr_sel` = 3 changes no gain.
- R8: A pixel accepted at the same edge as a write uses the gain held before that write. The next accepted pixel uses the new gain.
- R9: While `out_vld` is low, the three output components keep the values of the last emitted pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Gain register write strobe |
| wr_sel | input | 2 | Register select: 0 contrast, 1 Cb, 2 Cr, 3 none |
| wr_data | input | 8 | Gain code to write |
| in_vld | input | 1 | Input pixel valid |
| in_y | input | 8 | Input luma |
| in_cb | input | 8 | Input blue-difference chroma |
| in_cr | input | 8 | Input red-difference chroma |
| out_vld | output | 1 | Output pixel valid |
| out_y | output | 8 | Scaled luma |
| out_cb | output | 8 | Scaled Cb |
| out_cr | output | 8 | Scaled Cr |

## Verification
A gain write and a pixel acceptance can fall on the same clock edge. That is where the boundary between old and new gain is decided. The bench raises `wr_en` and `in_vld` in the same cycle, then sends a second pixel in the following cycle with identical component values. It judges the result by the two outputs: the first must match the reference computed with the previous code and the second the reference computed with the new one.

// File: rtl/ycc_gain_stage.sv
module ycc_gain_stage #(
  parameter int DW = 8,
  parameter int GW = 8,
  parameter int FRAC = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [GW-1:0] wr_data,
  input  logic          in_vld,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_cb,
  input  logic [DW-1:0] in_cr,
  output logic          out_vld,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_cb,
  output logic [DW-1:0] out_cr
);

  localparam int PW   = DW + GW;
  localparam int SPW  = DW + GW + 2;
  localparam logic [GW-1:0] UNITY = GW'(1 << FRAC);
  localparam int MID  = 1 << (DW - 1);
  localparam int MAXV = (1 << DW) - 1;

  logic [GW-1:0] g_y, g_cb, g_cr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_y  <= UNITY;
      g_cb <= UNITY;
      g_cr <= UNITY;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: g_y  <= wr_data;
        2'd1: g_cb <= wr_data;
        2'd2: g_cr <= wr_data;
        default: ;
      endcase
    end
  end

  logic signed [DW:0]    d_cb, d_cr;
  logic signed [SPW-1:0] m_cb, m_cr;
  logic [PW-1:0]         m_y;

  assign d_cb = $signed({1'b0, in_cb}) - $signed((DW+1)'(MID));
  assign d_cr = $signed({1'b0, in_cr}) - $signed((DW+1)'(MID));
  assign m_y  = PW'(in_y) * PW'(g_y);
  assign m_cb = SPW'(d_cb) * SPW'($signed({1'b0, g_cb}));
  assign m_cr = SPW'(d_cr) * SPW'($signed({1'b0, g_cr}));

  logic                  s1_vld;
  logic [PW-1:0]         s1_y;
  logic signed [SPW-1:0] s1_cb, s1_cr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_y   <= '0;
      s1_cb  <= '0;
      s1_cr  <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_y  <= m_y;
        s1_cb <= m_cb;
        s1_cr <= m_cr;
      end
    end
  end

  function automatic logic [DW-1:0] fin_y(input logic [PW-1:0] p);
    logic [PW:0] s;
    s = ({1'b0, p} + (PW+1)'(1 << (FRAC - 1))) >> FRAC;
    return (s > (PW+1)'(MAXV)) ? DW'(MAXV) : s[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] fin_c(input logic signed [SPW-1:0] p);
    logic signed [SPW-1:0] s;
    s = ((p + SPW'(1 << (FRAC - 1))) >>> FRAC) + SPW'(MID);
    if (s < 0) return '0;
    else if (s > SPW'(MAXV)) return DW'(MAXV);
    else return s[DW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_y   <= '0;
      out_cb  <= '0;
      out_cr  <= '0;
    end else begin
      out_vld <= s1_vld;
      if (s1_vld) begin
        out_y  <= fin_y(s1_y);
        out_cb <= fin_c(s1_cb);
        out_cr <= fin_c(s1_cr);
      end
    end
  end

endmodule

module ycc_gain_stage_chk #(
  parameter int DW = 8,
  parameter int GW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic [DW-1:0] in_y,
  input logic          out_vld,
  input logic [DW-1:0] out_y,
  input logic [DW-1:0] out_cb,
  input logic [DW-1:0] out_cr,
  input logic [GW-1:0] g_y,
  input logic [GW-1:0] g_cb,
  input logic [GW-1:0] g_cr
);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(in_vld, 2));

  assert_unity_luma_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_vld && g_y == GW'(128), 2) |-> out_y == $past(in_y, 2));

  assert_zero_luma_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_vld && g_y == '0, 2) |-> out_y == '0);

  assert_zero_cb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_vld && g_cb == '0, 2) |-> out_cb == DW'(128));

  assert_zero_cr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_vld && g_cr == '0, 2) |-> out_cr == DW'(128));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> ($stable(out_y) && $stable(out_cb) && $stable(out_cr)));

endmodule

bind ycc_gain_stage ycc_gain_stage_chk #(.DW(DW), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_y(in_y),
  .out_vld(out_vld), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr),
  .g_y(g_y), .g_cb(g_cb), .g_cr(g_cr)
);

// File: tb/sim_ycc_gain_stage.sv
`timescale 1ns/1ps
module sim_ycc_gain_stage;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic in_vld = 1'b0;
  logic [7:0] in_y = 8'h00, in_cb = 8'h00, in_cr = 8'h00;
  logic out_vld;
  logic [7:0] out_y, out_cb, out_cr;

  int checks = 0;
  int errors = 0;
  int gy = 128, gcb = 128, gcr = 128;

  always #2 clk = ~clk;

  ycc_gain_stage u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .in_vld(in_vld), .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
    .out_vld(out_vld), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
  );

  function automatic int fdiv128(input int v);
    return (v >= 0) ? v / 128 : -((-v + 127) / 128);
  endfunction

  function automatic int ref_y(input int y, input int g);
    int s;
    s = (y * g + 64) / 128;
    return (s > 255) ? 255 : s;
  endfunction

  function automatic int ref_c(input int c, input int g);
    int s;
    s = fdiv128((c - 128) * g + 64) + 128;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
    if (sel == 0) gy = data;
    else if (sel == 1) gcb = data;
    else if (sel == 2) gcr = data;
  endtask

  task automatic pix(input string req, input int y, input int cb, input int cr);
    @(negedge clk);
    in_vld = 1'b1; in_y = 8'(y); in_cb = 8'(cb); in_cr = 8'(cr);
    @(negedge clk);
    in_vld = 1'b0;
    chk({req, " early vld"}, int'(out_vld), 0);
    @(negedge clk);
    chk({req, " vld"}, int'(out_vld), 1);
    chk({req, " y"}, int'(out_y), ref_y(y, gy));
    chk({req, " cb"}, int'(out_cb), ref_c(cb, gcb));
    chk({req, " cr"}, int'(out_cr), ref_c(cr, gcr));
  endtask

  task automatic t_reset();
    chk("R1 vld", int'(out_vld), 0);
    chk("R1 y", int'(out_y), 0);
    chk("R1 cb", int'(out_cb), 0);
    chk("R1 cr", int'(out_cr), 0);
    pix("R1 unity defaults", 37, 201, 90);
  endtask

  task automatic t_unity_luma();
    pix("R3 unity", 0, 128, 128);
    pix("R3 unity", 255, 0, 255);
    wr(0, 8'h40);
    pix("R3 half", 100, 128, 128);
    pix("R3 half round", 101, 128, 128);
    wr(0, 8'hC0);
    pix("R3 1.5x", 77, 128, 128);
  endtask

  task automatic t_luma_edges();
    wr(0, 8'h00);
    pix("R4 zero", 255, 128, 128);
    wr(0, 8'hFF);
    pix("R4 sat", 200, 128, 128);
    pix("R4 below sat", 60, 128, 128);
    wr(0, 8'h80);
  endtask

  task automatic t_chroma();
    wr(1, 8'h00);
    wr(2, 8'h00);
    pix("R5 zero", 90, 0, 255);
    wr(1, 8'hFF);
    wr(2, 8'hFF);
    pix("R5 sat", 90, 0, 255);
    pix("R5 sat swap", 90, 255, 0);
    wr(1, 8'h40);
    wr(2, 8'h60);
    pix("R5 fractional", 90, 127, 129);
    pix("R5 fractional", 90, 30, 220);
  endtask

  task automatic t_independent();
    wr(1, 8'h80); wr(2, 8'h80); wr(0, 8'h80);
    wr(1, 8'h20);
    pix("R6 cb only", 150, 60, 60);
    chk("R6 y untouched", int'(out_y), 150);
    chk("R6 cr untouched", int'(out_cr), 60);
    wr(1, 8'h80);
    wr(2, 8'hE0);
    pix("R6 cr only", 150, 60, 60);
    chk("R6 cb untouched", int'(out_cb), 60);
  endtask

  task automatic t_select();
    wr(3, 8'h00);
    pix("R7 sel3 no effect", 180, 40, 210);
    wr(0, 8'h50);
    pix("R7 sel0", 180, 40, 210);
    wr(2, 8'h80);
    wr(0, 8'h80);
  endtask

  task automatic t_same_cycle();
    int oy;
    oy = gy;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h20;
    in_vld = 1'b1; in_y = 8'd200; in_cb = 8'd128; in_cr = 8'd128;
    @(negedge clk);
    wr_en = 1'b0;
    gy = 8'h20;
    in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    chk("R8 first vld", int'(out_vld), 1);
    chk("R8 first uses old gain", int'(out_y), ref_y(200, oy));
    @(negedge clk);
    chk("R8 second vld", int'(out_vld), 1);
    chk("R8 second uses new gain", int'(out_y), ref_y(200, gy));
    wr(0, 8'h80);
  endtask

  task automatic t_stream();
    int ys[5] = '{10, 250, 3, 129, 64};
    wr(0, 8'hA0);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R2 stream vld", int'(out_vld), 1);
        chk("R2 stream y", int'(out_y), ref_y(ys[i-2], gy));
      end
      if (i < 5) begin
        in_vld = 1'b1; in_y = 8'(ys[i]); in_cb = 8'd128; in_cr = 8'd128;
      end else begin
        in_vld = 1'b0;
      end
    end
    @(negedge clk);
    chk("R2 stream end", int'(out_vld), 0);
  endtask

  task automatic t_hold();
    pix("R9 seed", 222, 11, 244);
    in_y = 8'd5; in_cb = 8'd6; in_cr = 8'd7;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 idle vld", int'(out_vld), 0);
      chk("R9 hold y", int'(out_y), ref_y(222, gy));
      chk("R9 hold cb", int'(out_cb), ref_c(11, gcb));
      chk("R9 hold cr", int'(out_cr), ref_c(244, gcr));
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unity_luma();
    t_luma_edges();
    t_chroma();
    t_independent();
    t_select();
    t_same_cycle();
    t_stream();
    t_hold();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule